// File: doc/BRIEF.md
# Six-Bit Duty Chopper PWM Generator

This block produces the chopping waveform for a three-phase bridge driver. A free-running period counter divides the system clock by 256. A six-bit duty code from an external converter sets the on-time in steps of four clocks. Two range flags from the same converter override the code. When the input is under the conversion range, the duty is forced to zero. When it is over the range, the duty is forced to the maximum of 63/64. The code and the flags are sampled once per period, on the last clock of the period, so that a period never changes width part way through.

The chopped waveform is ANDed with per-phase high-side and low-side enables, which come from the commutation logic, and with the inverse of a digital overcurrent flag. The same gated waveform drives a duty monitor pin. An active overcurrent therefore silences the monitor as well as the bridge, in the same cycle and without a register in the path.

A one-clock sample strobe marks every falling edge of the internal, ungated waveform, so that back-EMF comparison can be timed to the end of each on-time. All inputs are plain level controls that are sampled when the block needs them. There is no valid/ready handshake and no back-pressure: the converter simply holds its latest result.

Top module: `pwm6_gen`

## Requirements
- R1: The PWM period is exactly 256 clocks. For a nonzero latched duty, the waveform rises only on the clock where the period position is 0.
- R2: With both range flags low, a latched duty code n (0 to 63) gives an on-time of 4×n clocks, at period positions 0 to 4n−1.
- R3: When `below_low` is high at the load point, the next period has zero duty, whatever the values of `duty_code` and `above_high`.
- R4: When `above_high` is high and `below_low` is low at the load point, the next period has 252 clocks on (63/64), whatever the value of `duty_code`.
- R5: The code and flags are sampled only on the clock where the period position is 255. A change at any other time has no effect on the period in progress.
- R6: While `overcurrent` is high, every bridge output and `duty_mon` are low in that same cycle.
- R7: Each `bridge_hi[i]` equals `phase_hi_en[i]` AND the gated PWM, and each `bridge_lo[i]` equals `phase_lo_en[i]` AND the gated PWM, for i = 0 to 2 (bit i is phase i).
- R8: `duty_mon` carries the internal PWM gated by the inverse of `overcurrent`.
- R9: `sample_stb` is high for exactly one clock after each falling edge of the internal, ungated PWM, at period position 4n. It is not affected by `overcurrent`.
- R10: During reset and for the first 256 clocks after reset, all outputs are low, because the latched duty resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_code | input | 6 | Duty code from the converter, on-time 4×n clocks |
| below_low | input | 1 | Converter input under range: forces zero duty |
| above_high | input | 1 | Converter input over range: forces 63/64 duty |
| overcurrent | input | 1 | Overcurrent flag, active high, immediate kill |
| phase_hi_en | input | 3 | High-side enables from the commutation logic |
| phase_lo_en | input | 3 | Low-side enables from the commutation logic |
| bridge_hi | output | 3 | Gated high-side drive |
| bridge_lo | output | 3 | Gated low-side drive |
| duty_mon | output | 1 | Gated PWM monitor |
| sample_stb | output | 1 | One-clock strobe on each PWM falling edge |

## Verification
The bench targets the ends of the code range: code 0 inside the range, code 1 and code 63. A wrong compare width or step shift gives the wrong on-time there, or a waveform that never falls. It sets both range flags at once and holds a code under each flag. A wrong priority lets the code or the high flag leak through. It changes the code in the middle of a period, which catches a design that loads the code at the wrong time or uses it with no latch. It pulses overcurrent in the middle of on-times and checks that the bridge and the monitor drop in that same cycle while the sample strobe keeps firing, which catches a registered kill path or a strobe taken from the gated waveform.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  localparam int unsigned PER_BITS   = 8;
  localparam int unsigned CODE_BITS  = 6;
  localparam int unsigned STEP_SHIFT = PER_BITS - CODE_BITS;
  localparam int unsigned N_PHASE    = 3;
  typedef logic [PER_BITS-1:0]  pos_t;
  typedef logic [CODE_BITS-1:0] code_t;
endpackage

// File: rtl/pwm6_period_ctr.sv
module pwm6_period_ctr
  import pwm6_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output pos_t pos,
  output logic last
);
  always_ff @(posedge clk) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos + 1'b1;
  end

  assign last = (pos == {PER_BITS{1'b1}});
endmodule

// File: rtl/pwm6_duty_sel.sv
module pwm6_duty_sel
  import pwm6_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  code_t code_in,
  input  logic  under,
  input  logic  over,
  output code_t code_q
);
  code_t eff;

  always_comb begin
    if (under)     eff = '0;
    else if (over) eff = {CODE_BITS{1'b1}};
    else           eff = code_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= eff;
  end
endmodule

// File: rtl/pwm6_compare.sv
module pwm6_compare
  import pwm6_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pos_t  pos,
  input  code_t code_q,
  output logic  pwm,
  output logic  fall_stb
);
  pos_t thresh;
  logic pwm_d;

  assign thresh   = {code_q, {STEP_SHIFT{1'b0}}};
  assign pwm      = (pos < thresh);
  assign fall_stb = pwm_d & ~pwm;

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_d <= 1'b0;
    else        pwm_d <= pwm;
  end
endmodule

// File: rtl/pwm6_gen.sv
module pwm6_gen
  import pwm6_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [5:0]          duty_code,
  input  logic                below_low,
  input  logic                above_high,
  input  logic                overcurrent,
  input  logic [2:0]          phase_hi_en,
  input  logic [2:0]          phase_lo_en,
  output logic [2:0]          bridge_hi,
  output logic [2:0]          bridge_lo,
  output logic                duty_mon,
  output logic                sample_stb
);
  pos_t  pos;
  logic  last;
  code_t code_q;
  logic  pwm;
  logic  live;

  pwm6_period_ctr u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .pos  (pos),
    .last (last)
  );

  pwm6_duty_sel u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last),
    .code_in(duty_code),
    .under  (below_low),
    .over   (above_high),
    .code_q (code_q)
  );

  pwm6_compare u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos     (pos),
    .code_q  (code_q),
    .pwm     (pwm),
    .fall_stb(sample_stb)
  );

  assign live     = pwm & ~overcurrent;
  assign duty_mon = live;

  for (genvar i = 0; i < N_PHASE; i++) begin : g_phase
    assign bridge_hi[i] = phase_hi_en[i] & live;
    assign bridge_lo[i] = phase_lo_en[i] & live;
  end
endmodule

// File: rtl/pwm6_gen_chk.sv
module pwm6_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       overcurrent,
  input logic [2:0] bridge_hi,
  input logic [2:0] bridge_lo,
  input logic       duty_mon,
  input logic       sample_stb
);
  logic [7:0] ccnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ccnt <= '0;
    else        ccnt <= ccnt + 1'b1;
  end

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R9
  strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (ccnt[1:0] == 2'b00 && ccnt != 8'd0));

  // R6
  oc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overcurrent |-> (bridge_hi == 3'b000 && bridge_lo == 3'b000 && !duty_mon));

  // R1
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(duty_mon) && !overcurrent && !$past(overcurrent)) |-> ccnt == 8'd0);

  // R7
  bridge_needs_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bridge_hi || |bridge_lo) |-> duty_mon);
endmodule

bind pwm6_gen pwm6_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .overcurrent(overcurrent),
  .bridge_hi  (bridge_hi),
  .bridge_lo  (bridge_lo),
  .duty_mon   (duty_mon),
  .sample_stb (sample_stb)
);

// File: tb/pwm6_gen_test.sv
`timescale 1ns/1ps
module pwm6_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] duty_code = '0;
  logic       below_low = 1'b0, above_high = 1'b0, overcurrent = 1'b0;
  logic [2:0] phase_hi_en = '0, phase_lo_en = '0;
  logic [2:0] bridge_hi, bridge_lo;
  logic       duty_mon, sample_stb;

  int total = 0, bad = 0;
  bit done = 0;
  int mcnt = 0, cur = 0, pend = 0;
  string cur_tag = "R10", pend_tag = "R2";
  bit prev_pwm = 0, oc_seen = 0, mid_flag = 0;
  int hi_cnt = 0;

  always #2 clk = ~clk;

  pwm6_gen uut (.*);

  function automatic int eff_code(int code, bit lo, bit hi);
    if (lo) return 0;
    if (hi) return 63;
    return code;
  endfunction

  function automatic string tag_of(bit lo, bit hi);
    if (lo) return "R3";
    if (hi) return "R4";
    return "R2";
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (pos %0d)", req, act, exp, mcnt);
    end
  endtask

  task automatic step();
    bit epwm, elive;
    if (mcnt == 255) begin
      pend = eff_code(duty_code, below_low, above_high);
      pend_tag = mid_flag ? "R5" : tag_of(below_low, above_high);
    end
    @(posedge clk);
    mcnt = (mcnt + 1) % 256;
    if (mcnt == 0) begin cur = pend; cur_tag = pend_tag; end
    @(negedge clk);
    epwm  = (mcnt < 4 * cur);
    elive = epwm & ~overcurrent;
    // R1 R8 monitor, R6 when overcurrent is active
    check(overcurrent ? "R6" : (cur_tag == "R5" ? "R5" : "R8"), duty_mon, elive);
    // R7 bridge gating
    check("R7", {bridge_hi, bridge_lo},
          {phase_hi_en & {3{elive}}, phase_lo_en & {3{elive}}});
    // R9 strobe from the ungated waveform
    check("R9", sample_stb, prev_pwm & ~epwm);
    prev_pwm = epwm;
    if (duty_mon) hi_cnt++;
    if (overcurrent) oc_seen = 1;
    if (mcnt == 255) begin
      // R1 R2 R3 R4 on-time per 256-clock period
      if (!oc_seen) check(cur_tag, hi_cnt, 4 * cur);
      hi_cnt = 0; oc_seen = 0;
    end
  endtask

  task automatic run_period(int code, bit lo, bit hi, bit oc_pulse, bit mid);
    phase_hi_en = 3'($urandom);
    phase_lo_en = 3'($urandom);
    duty_code = 6'(code); below_low = lo; above_high = hi;
    mid_flag = 0;
    for (int i = 0; i < 256; i++) begin
      if (mid && i == 100) begin duty_code = ~duty_code; below_low = ~lo; end
      if (mid && i == 200) begin duty_code = 6'(code); below_low = lo; mid_flag = 1; end
      overcurrent = oc_pulse && (i >= 1 && i <= 6 || i >= 30 && i <= 33);
      step();
    end
    overcurrent = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    phase_hi_en = 3'b111; phase_lo_en = 3'b111; duty_code = 6'd40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10", {bridge_hi, bridge_lo, duty_mon, sample_stb}, 0);
    rst_n = 1'b1;
    // R10 first period after reset stays off regardless of inputs
    run_period(40, 0, 0, 0, 0);
    run_period(0, 0, 0, 0, 0);
    run_period(1, 0, 0, 0, 0);
    run_period(63, 0, 0, 0, 0);
    run_period(40, 1, 0, 0, 0);
    run_period(5, 0, 1, 0, 0);
    run_period(22, 1, 1, 0, 0);
    run_period(17, 0, 0, 0, 1);
    run_period(50, 0, 0, 1, 0);
    run_period(63, 0, 1, 1, 0);
    for (int p = 0; p < 24; p++)
      run_period(int'($urandom_range(63)), ($urandom_range(7) == 0),
                 ($urandom_range(5) == 0), ($urandom_range(2) == 0),
                 ($urandom_range(4) == 0));
    run_period(0, 0, 0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule